// File: doc/BRIEF.md
# Latched Channel-Select Decoder

This block is the digital control front end of an eight-way analog switch bank. It captures a three-bit channel address and an enable bit from a processor bus and turns them into eight switch-enable lines. At most one of those lines is on at any time. When the captured enable bit is clear, all of the lines are off.

The block behaves as a write-only register. The held value follows the bus while the active-low write strobe is low. It freezes on the last value taken while the strobe was low, and keeps that value until the next strobe-low period. A master clear forces the held value to "address 0, disabled", which turns every switch off.

The design is fully synchronous. The level-sensitive capture is emulated by sampling the bus on each clock edge while the strobe is low. The clear is an active-high synchronous input. The switch lines come from a registered decode of the held value.

Top module: `chsel_latch_dec`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, the held address and enable are cleared to address 0 with enable 0, and `sw` is 8'h00 after that edge. The values of `wr_n`, `en` and `addr` have no effect on this.
- R2: After `rst` returns to 0 while `wr_n` stays 1, `sw` stays 8'h00 until a write takes place.
- R3: While `wr_n` is 0 at a rising edge, the held value takes on the `{en, addr}` present at that edge. `sw` reflects the new held value after the following edge, which is one cycle of output latency.
- R4: While `wr_n` is 1 at a rising edge, the held value does not change. Changes on `en` and `addr` during that time have no effect on `sw`.
- R5: On the first edge at which `wr_n` has returned to 1, the held value is the one taken at the last edge at which `wr_n` was 0.
- R6: With held enable 1, `sw[i]` is 1 exactly when the held address equals i, and every other bit is 0. Bit i corresponds to binary address i.
- R7: With held enable 0, `sw` is 8'h00 whatever the held address is.
- R8: At no time is more than one bit of `sw` set.
- R9: With `wr_n` held at 0 permanently, `sw` equals the one-hot decode of the `{en, addr}` presented two edges earlier. The decode gives bit `addr` when `en` is 1, and 8'h00 when `en` is 0.
- R10: The clear has priority over the strobe. When `rst` falls while `wr_n` is already 0, the first edge after release captures the current inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high master clear |
| wr_n | input | 1 | Active-low write strobe |
| en | input | 1 | Enable bit to capture |
| addr | input | 3 | Channel address to capture |
| sw | output | 8 | Registered one-hot switch enables |

## Verification
The clear and a write can fall in the same cycle. The bench drives `rst` high while the strobe is low with enable 1 and a non-zero address, and it expects all-off, because the clear takes priority. The clear is then released with the strobe still low, and the bench expects the very next edge to capture the bus. A strobe release in the same edge as a new bus value is also exercised. The bench judges that case by requiring that the held value is the one captured one edge earlier.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  localparam int CHSEL_ADDR_W_DEF = 3;

  function automatic int chsel_channels(input int addr_w);
    return 1 << addr_w;
  endfunction
endpackage

// File: rtl/chsel_hold.sv
module chsel_hold #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else if (!wr_n) begin
      q_r <= d;
    end
  end

  assign q = q_r;

  // R3 and R10: transparent capture while the strobe is low
  a_r3_follow: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> q == $past(d));

  // R4 and R5: held value frozen while the strobe is high
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    wr_n |=> $stable(q));
endmodule

// File: rtl/chsel_decode.sv
module chsel_decode #(
  parameter int ADDR_W = 3,
  localparam int N = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N-1:0]      sw
);
  logic [N-1:0] sw_d;
  logic [N-1:0] sw_q;
  logic         rst_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign sw_d[i] = en_i && (addr_i == ADDR_W'(i));
  end

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      sw_q <= '0;
    end else begin
      sw_q <= sw_d;
    end
  end

  assign sw = sw_q;

  // R8: never more than one switch on
  a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sw));

  // R7: held enable clear turns everything off
  a_r7_disable: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> sw == '0);

  // R6: held enable set selects exactly the addressed line
  a_r6_select: assert property (@(posedge clk) disable iff (rst)
    en_i |=> ($countones(sw) == 1) && sw[$past(addr_i)]);

  // R1: outputs are off after a clear edge
  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      a_r1_clear: assert (sw == '0);
    end
  end
endmodule

// File: rtl/chsel_latch_dec.sv
module chsel_latch_dec #(
  parameter int ADDR_W = chsel_pkg::CHSEL_ADDR_W_DEF,
  localparam int N = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [N-1:0]      sw
);
  localparam int HW = ADDR_W + 1;

  logic [HW-1:0] held;

  chsel_hold #(.W(HW)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .wr_n (wr_n),
    .d    ({en, addr}),
    .q    (held)
  );

  chsel_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk    (clk),
    .rst    (rst),
    .en_i   (held[HW-1]),
    .addr_i (held[ADDR_W-1:0]),
    .sw     (sw)
  );

  // R2: clear followed by no write keeps everything off
  a_r2_stay_off: assert property (@(posedge clk) disable iff (rst)
    (held == '0) |=> sw == '0);
endmodule

// File: tb/chsel_latch_dec_test.sv
module chsel_latch_dec_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_n = 1'b1;
  logic       en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] sw;

  int vectors = 0;
  int miscompares = 0;
  logic [3:0] m_hold = 4'd0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];

  always #2 clk = ~clk;

  chsel_latch_dec uut (
    .clk(clk), .rst(rst), .wr_n(wr_n), .en(en), .addr(addr), .sw(sw)
  );

  function automatic logic [7:0] dec(input logic [3:0] h);
    return h[3] ? (8'd1 << h[2:0]) : 8'd0;
  endfunction

  task automatic vec(input logic r, input logic w, input logic e,
                     input logic [2:0] a, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; wr_n = w; en = e; addr = a;
    it.exp = r ? 8'd0 : dec(m_hold);
    it.tag = tag;
    sbq.push_back(it);
    if (r) m_hold = 4'd0;
    else if (!w) m_hold = {e, a};
  endtask

  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      vectors++;
      if (sw !== it.exp) begin
        miscompares++;
        $display("FAIL %s: sw=%h expected %h", it.tag, sw, it.exp);
      end
      if ($countones(sw) > 1) begin
        miscompares++;
        $display("FAIL R8: sw=%h expected at most one bit", sw);
      end
    end
  end

  initial begin
    #100000;
    miscompares++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int unsigned lcg = 32'h1234_5678;
    // R1: clear coinciding with a write
    vec(1, 0, 1, 3'd5, "R1");
    vec(1, 0, 1, 3'd5, "R1");
    // R2: released with strobe high
    vec(0, 1, 1, 3'd3, "R2");
    vec(0, 1, 1, 3'd6, "R2");
    vec(0, 1, 0, 3'd1, "R2");
    // R3: write
    vec(0, 0, 1, 3'd3, "R3");
    vec(0, 1, 1, 3'd3, "R3");
    // R4: inputs move while strobe high
    vec(0, 1, 1, 3'd7, "R4");
    vec(0, 1, 0, 3'd0, "R4");
    vec(0, 1, 1, 3'd1, "R4");
    // R5: new value at strobe release is not kept
    vec(0, 0, 1, 3'd2, "R5");
    vec(0, 1, 1, 3'd6, "R5");
    vec(0, 1, 1, 3'd6, "R5");
    // R6: every address
    for (int i = 0; i < 8; i++) vec(0, 0, 1, 3'(i), "R6");
    // R7: enable clear with various addresses
    vec(0, 0, 0, 3'd4, "R7");
    vec(0, 0, 0, 3'd7, "R7");
    vec(0, 1, 1, 3'd2, "R7");
    vec(0, 1, 1, 3'd2, "R7");
    // R10: release while strobe already low
    vec(1, 0, 1, 3'd4, "R10");
    vec(0, 0, 1, 3'd7, "R10");
    vec(0, 0, 1, 3'd7, "R10");
    vec(0, 0, 1, 3'd7, "R10");
    // R9: strobe low permanently, pseudo-random bus
    for (int i = 0; i < 40; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      vec(0, 0, lcg[20], lcg[26:24], "R9");
    end
    vec(0, 1, 0, 3'd0, "R9");
    vec(0, 1, 0, 3'd0, "R9");
    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule